// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block is a single data-watch channel that sits beside a load/store pipeline. Software programs a watch address and a control word. Every access the pipeline presents is compared against the armed setting in the same cycle. A hit is signalled combinationally, so the pipeline can suppress the access before it commits. The control word carries a store-arm bit, a load-arm bit and a six-bit mask field. The mask field, with all higher address bits forced to one, selects an aligned window of 1 to 64 bytes.

A mask field whose ones do not form a single run from its top bit is not rejected. It is repaired by keeping only the leading ones and clearing everything from the first zero downward. A sticky configuration-error flag records that a repair took place. The comparator keeps its own armed copy of the settings. That copy is refreshed when the arm bits or the repaired mask change, or when the watch address changes while the channel is armed. The access port is a plain strobe with no back-pressure: the block never stalls the pipeline, and `acc_valid` is sampled only for the cycle in which it is high.

Top module: `dbk_channel`

## Requirements
- R1: Control bit 31 arms the channel for stores (`acc_is_store`=1). A store can hit only while this bit is armed.
- R2: Control bit 30 arms the channel for loads (`acc_is_store`=0). A load can hit only while this bit is armed. With bits 31 and 30 both clear, `hit` stays low for every access.
- R3: The effective mask has the repaired 6-bit field (control bits 5:0) in bits 5:0 and ones in bits 31:6. An access hits when (acc_addr AND mask) equals (watch address AND mask). The window is therefore (NOT mask)+1 bytes long, from 1 to 64, aligned to its size.
- R4: A control write whose mask field is not ones-then-zeros is repaired. Every field bit at or below the highest zero is cleared, for example 110100 becomes 110000.
- R5: `cfg_err` is loaded on every control write: 1 if the written field needed repair, 0 otherwise. It holds its value across all other cycles, including address writes.
- R6: `hit` depends combinationally on the access inputs in the cycle that `acc_valid` is high. A register write takes effect for accesses from the cycle after the write strobe.
- R7: An address write while the channel is disarmed is held and does not cause hits. Once a later control write arms the channel, the held address is the one compared. An address write while the channel is armed moves the window from the next cycle.
- R8: After reset both registers are zero. The channel is disarmed, `hit` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr_en | input | 1 | Write strobe for the watch address |
| addr_wr_data | input | 32 | New watch address |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 32 | Control word: bit 31 store arm, bit 30 load arm, bits 5:0 mask field, the other bits ignored |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | Access falls in the armed window, valid in the same cycle |
| cfg_err | output | 1 | Last control write carried a non-contiguous mask field |

## Verification
A wrong armed mask or base shows up at `hit` in the first access after the faulty write. It appears as a window edge one byte off, a window of the wrong size, or a miss on an address whose high bits should match. The bench sweeps all 64 mask fields and probes both edges of each window and the bytes just outside it. A stale arm bit or a lost held address appears on the first probe after the enabling write. A sticky-flag fault appears on `cfg_err` immediately after the write, or after an intervening address write.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/dbk_mask_fix.sv
module dbk_mask_fix #(
  parameter int MW = 6
) (
  input  logic [MW-1:0] raw_field,
  output logic [MW-1:0] fixed_field,
  output logic          needed_fix
);
  // bit i survives only if every bit from the top down to i is one
  for (genvar i = 0; i < MW; i++) begin : g_prefix
    assign fixed_field[i] = &raw_field[MW-1:i];
  end
  assign needed_fix = (fixed_field != raw_field);
endmodule

// File: rtl/dbk_arm_regs.sv
module dbk_arm_regs #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr_en,
  input  logic [AW-1:0] addr_wr_data,
  input  logic          ctl_wr_en,
  input  logic [CW-1:0] ctl_wr_data,
  output logic [AW-1:0] arm_base,
  output logic [MW-1:0] arm_field,
  output logic          arm_st,
  output logic          arm_ld,
  output logic          cfg_err
);
  localparam int ST_BIT = CW - 1;
  localparam int LD_BIT = CW - 2;

  logic [AW-1:0] addr_q, addr_d;
  logic          st_q, st_d, ld_q, ld_d;
  logic [MW-1:0] field_q, field_d;
  logic [MW-1:0] wr_field_fixed;
  logic          wr_field_bad;
  logic          rearm;
  logic          unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wr_data[LD_BIT-1:MW];

  dbk_mask_fix #(.MW(MW)) u_fix (
    .raw_field  (ctl_wr_data[MW-1:0]),
    .fixed_field(wr_field_fixed),
    .needed_fix (wr_field_bad)
  );

  always_comb begin
    addr_d  = addr_wr_en ? addr_wr_data : addr_q;
    st_d    = ctl_wr_en ? ctl_wr_data[ST_BIT] : st_q;
    ld_d    = ctl_wr_en ? ctl_wr_data[LD_BIT] : ld_q;
    field_d = ctl_wr_en ? wr_field_fixed : field_q;
    rearm   = (st_d != st_q) || (ld_d != ld_q) || (field_d != field_q) ||
              ((st_d || ld_d) && (addr_d != addr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      st_q     <= 1'b0;
      ld_q     <= 1'b0;
      field_q  <= '0;
      cfg_err  <= 1'b0;
      arm_base <= '0;
      arm_field<= '0;
      arm_st   <= 1'b0;
      arm_ld   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      st_q    <= st_d;
      ld_q    <= ld_d;
      field_q <= field_d;
      if (ctl_wr_en) cfg_err <= wr_field_bad;
      if (rearm) begin
        arm_base  <= addr_d;
        arm_field <= field_d;
        arm_st    <= st_d;
        arm_ld    <= ld_d;
      end
    end
  end

  logic [MW-1:0] inv_field;
  assign inv_field = ~arm_field;

  always_comb begin
    if (rst_n) begin
      assert_field_contig_R4: assert ((inv_field & (inv_field + 1'b1)) == '0)
        else $error("armed mask field not contiguous");
    end
  end

  assert_arm_follows_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (arm_st == $past(ctl_wr_data[ST_BIT])) &&
                  (arm_ld == $past(ctl_wr_data[LD_BIT])));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(cfg_err));

  assert_base_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr_en && !ctl_wr_en && (arm_st || arm_ld)) |=> arm_base == $past(addr_wr_data));
endmodule

// File: rtl/dbk_match.sv
module dbk_match
  import dbk_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 6
) (
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  acc_kind_e     acc_kind,
  input  logic [AW-1:0] arm_base,
  input  logic [MW-1:0] arm_field,
  input  logic          arm_st,
  input  logic          arm_ld,
  output logic          hit
);
  localparam int HW = AW - MW;

  logic [AW-1:0] eff_mask;
  logic          kind_armed;
  logic          in_window;

  assign eff_mask   = {{HW{1'b1}}, arm_field};
  assign kind_armed = (acc_kind == ACC_STORE) ? arm_st : arm_ld;
  assign in_window  = ((acc_addr ^ arm_base) & eff_mask) == '0;
  assign hit        = acc_valid && kind_armed && in_window;

  always_comb begin
    if (hit) begin
      assert_high_bits_match_R3: assert (acc_addr[AW-1:MW] == arm_base[AW-1:MW])
        else $error("hit outside the high address bits");
    end
  end
endmodule

// File: rtl/dbk_channel.sv
module dbk_channel
  import dbk_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr_en,
  input  logic [AW-1:0] addr_wr_data,
  input  logic          ctl_wr_en,
  input  logic [CW-1:0] ctl_wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_is_store,
  output logic          hit,
  output logic          cfg_err
);
  logic [AW-1:0] arm_base;
  logic [MW-1:0] arm_field;
  logic          arm_st, arm_ld;
  acc_kind_e     acc_kind;

  assign acc_kind = acc_is_store ? ACC_STORE : ACC_LOAD;

  dbk_arm_regs #(.AW(AW), .CW(CW), .MW(MW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_wr_en  (addr_wr_en),
    .addr_wr_data(addr_wr_data),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .arm_base    (arm_base),
    .arm_field   (arm_field),
    .arm_st      (arm_st),
    .arm_ld      (arm_ld),
    .cfg_err     (cfg_err)
  );

  dbk_match #(.AW(AW), .MW(MW)) u_match (
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .acc_kind (acc_kind),
    .arm_base (arm_base),
    .arm_field(arm_field),
    .arm_st   (arm_st),
    .arm_ld   (arm_ld),
    .hit      (hit)
  );

  assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_st && !arm_ld) |-> !hit);
endmodule

// File: tb/dbk_channel_test.sv
`timescale 1ns/1ps
module dbk_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr_en = 1'b0;
  logic [31:0] addr_wr_data = '0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_store = 1'b0;
  logic        hit, cfg_err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dbk_channel uut (
    .clk(clk), .rst_n(rst_n),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_store(acc_is_store),
    .hit(hit), .cfg_err(cfg_err)
  );

  task automatic check(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wctl(input bit st, input bit ld, input logic [5:0] f);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = {st, ld, 24'hA5C35A, f};
    @(negedge clk);
    ctl_wr_en   = 1'b0;
  endtask

  task automatic waddr(input logic [31:0] a);
    @(negedge clk);
    addr_wr_en   = 1'b1;
    addr_wr_data = a;
    @(negedge clk);
    addr_wr_en   = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input bit st, input bit exp, input string req);
    acc_valid    = 1'b1;
    acc_addr     = a;
    acc_is_store = st;
    #1;
    check(hit, exp, req);
    acc_valid = 1'b0;
    #0.5;
  endtask

  // leading-ones count gives the repaired field
  function automatic logic [5:0] fix_field(input logic [5:0] f);
    int n = 0;
    while (n < 6 && f[5-n]) n++;
    return ~(6'h3F >> n);
  endfunction

  initial begin
    #(100000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(cfg_err, 1'b0, "R8 cfg_err");
    probe(32'h0, 1'b1, 1'b0, "R8 store");
    probe(32'h0, 1'b0, 1'b0, "R8 load");

    // R3/R4/R5 sweep of every mask field
    for (int f = 0; f < 64; f++) begin
      logic [31:0] base, m, sz, lo;
      logic [5:0]  fx;
      base = 32'h4006_1000 + (f * 32'h0001_0337);
      fx   = fix_field(f[5:0]);
      m    = {26'h3FFFFFF, fx};
      sz   = ~m + 1;
      lo   = base & m;
      waddr(base);
      wctl(1'b1, 1'b1, f[5:0]);
      check(cfg_err, fx != f[5:0], "R5 flag after write");
      probe(lo,            1'b1, 1'b1, "R3 window start");
      probe(lo + sz - 1,   1'b0, 1'b1, "R3 window end");
      probe(lo + sz,       1'b1, 1'b0, "R4 past end");
      probe(lo - 1,        1'b0, 1'b0, "R4 before start");
      probe(lo + (sz >> 1),1'b1, 1'b1, "R3 middle");
      probe(lo ^ 32'h0002_0000, 1'b0, 1'b0, "R3 high bit differs");
    end

    // R4 explicit repair 110100 -> 110000 (16 bytes)
    waddr(32'h0000_2000);
    wctl(1'b1, 1'b1, 6'b110100);
    check(cfg_err, 1'b1, "R4 flag");
    probe(32'h0000_200C, 1'b1, 1'b1, "R4 repaired window covers +12");
    probe(32'h0000_2010, 1'b1, 1'b0, "R4 repaired window ends at +16");

    // R5 flag held across an address write, cleared by a clean write
    waddr(32'h0000_3000);
    check(cfg_err, 1'b1, "R5 held over address write");
    wctl(1'b1, 1'b1, 6'b111100);
    check(cfg_err, 1'b0, "R5 cleared");

    // R1 store-only
    wctl(1'b1, 1'b0, 6'b111100);
    probe(32'h0000_3002, 1'b1, 1'b1, "R1 store hits");
    probe(32'h0000_3002, 1'b0, 1'b0, "R1 load ignored");
    // R2 load-only
    wctl(1'b0, 1'b1, 6'b111100);
    probe(32'h0000_3002, 1'b0, 1'b1, "R2 load hits");
    probe(32'h0000_3002, 1'b1, 1'b0, "R2 store ignored");
    // R2 both clear
    wctl(1'b0, 1'b0, 6'b000000);
    for (int k = 0; k < 64; k += 9) begin
      probe(32'h0000_3000 + k, 1'b1, 1'b0, "R2 disarmed store");
      probe(32'h0000_3000 + k, 1'b0, 1'b0, "R2 disarmed load");
    end

    // R7 address written while disarmed
    waddr(32'h0000_5000);
    probe(32'h0000_5000, 1'b1, 1'b0, "R7 disarmed no hit");
    // R6 during the enabling write cycle the old (disarmed) state applies
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = {2'b11, 24'h0, 6'b111000};
    probe(32'h0000_5000, 1'b1, 1'b0, "R6 write not yet effective");
    @(negedge clk);
    ctl_wr_en = 1'b0;
    probe(32'h0000_5007, 1'b1, 1'b1, "R7 held address armed");
    probe(32'h0000_3000, 1'b1, 1'b0, "R7 old address gone");
    // R7 address moved while armed
    waddr(32'h0000_6008);
    probe(32'h0000_600F, 1'b0, 1'b1, "R7 moved window");
    probe(32'h0000_5000, 1'b0, 1'b0, "R7 previous window gone");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule